// File: doc/BRIEF.md
# Timing-Command Monitor with Run Control

This block watches a stream of 8-bit broadcast timing commands, each flagged by a one-cycle valid strobe. It holds the most recent command and keeps a saturating occurrence count for each command code from 0 to 15. A three-state run machine (IDLE, RUN, HALT) decides when the timing-clock and receive-clock cycle counters may advance. A host moves the run machine by setting bits in a write-only pulse register. When enabled in the control register, two timing command codes can also start and stop the run. A bunch-zero marker counter and a lock-status view with a lock-loss counter complete the monitor.

Everything is reached over a simple 16-bit local bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The timing clock, the receive clock and the lock flag come from other clock domains. They pass through two-flop synchronizers into the bus clock domain, and the clocks are edge-detected there.

A differential test output is driven as a static level from control bit 0. It is also pulsed high for exactly one bus cycle by a write to the pulse register.

Run machine states and transitions:
- IDLE is entered after reset or after a hard reset.
- LAUNCH moves IDLE to RUN on a start request.
- HALT moves RUN to HALT on a stop request that has no start request with it.
- RESUME moves HALT to RUN on a start request.
- CLEAR moves any state to IDLE on a hard reset. CLEAR overrides every other transition.

Top module: `tcm_monitor`

## Requirements
- R1: Address 0x01 reads 0xFFFF, address 0x02 reads 0x0000 and address 0x03 reads the VERSION parameter (default 0x7003). Addresses that are not mapped, including the write-only address 0x61, read 0x0000.
- R2: The control register at address 0x00 is read/write over all 16 bits. Its bit 0 drives `test_out_p` high as a level, and `test_out_n` is always the complement of `test_out_p`.
- R3: A write to address 0x61 with bit 1 set is a start request and with bit 2 set is a stop request. The run state changes on the write edge. Status bit 1 (address 0x10) reads 1 only in RUN. A start request and a stop request in the same write leave the machine in RUN.
- R4: When control bit 11 is 1, a valid command equal to CMD_START (default 0x01) is a start request and one equal to CMD_STOP (default 0x02) is a stop request. When bit 11 is 0, these commands do not change the run state.
- R5: Address 0x18 returns the last valid command in bits 7:0, with bits 15:8 reading 0.
- R6: Address 0x20+c returns the number of valid commands whose value equals c, for c from 0 to 15. Commands of value 16 or more are counted in no bin.
- R7: The counter at 0x3D counts rising edges of the timing clock input only while in RUN.
- R8: The counter at 0x3E counts rising edges of the receive clock input only while in RUN.
- R9: Bit 3 of a write to 0x61 (soft reset) clears the 0x3D and 0x3E counters. It leaves the run state, the histogram and the bunch-zero counter unchanged.
- R10: The counter at 0x40 counts bus cycles in which the bunch-zero input is high, whatever the run state.
- R11: Every 16-bit counter stops at 0xFFFF instead of wrapping.
- R12: Bit 0 of a write to 0x61 (hard reset) clears the control register, the last command, all counters and the lock-loss counter, and returns the run machine to IDLE.
- R13: Bit 5 of a write to 0x61 drives `test_out_p` high for exactly the one cycle after the write edge, unless control bit 0 holds it high anyway.
- R14: Status bit 3 shows the synchronized lock input. Status bits 10:8 count falling edges of the lock input and stop at 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Local bus register address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| tcmd | input | 8 | Broadcast timing command value |
| tcmd_vld | input | 1 | Command valid strobe, one command per high cycle |
| tclk_in | input | 1 | Timing clock, asynchronous to clk |
| rxclk_in | input | 1 | Receive clock, asynchronous to clk |
| bc0_in | input | 1 | Bunch-zero marker, synchronous to clk |
| tlock_in | input | 1 | Timing clock lock flag, asynchronous to clk |
| test_out_p | output | 1 | Differential test output, true side |
| test_out_n | output | 1 | Differential test output, complement side |

## Verification
The assertions assume three things about the inputs:
- the command strobe and the bunch-zero marker are already synchronous to the bus clock;
- the two sampled clocks and the lock flag hold each level for at least two bus cycles, so no edge is lost in the synchronizers;
- the bus issues at most one write per cycle.

The bench drives commands and markers at the falling edge of the bus clock. It holds every sampled clock phase for three bus cycles. It waits four cycles after the last edge, covering the two synchronizer stages and the counter register, before it reads a counter.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_RUN  = 2'd1,
        RS_HALT = 2'd2
    } run_state_e;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_ONES  = 8'h01;
    localparam logic [7:0] A_ZEROS = 8'h02;
    localparam logic [7:0] A_VER   = 8'h03;
    localparam logic [7:0] A_STAT  = 8'h10;
    localparam logic [7:0] A_LAST  = 8'h18;
    localparam logic [7:0] A_HIST  = 8'h20;
    localparam logic [7:0] A_TCNT  = 8'h3D;
    localparam logic [7:0] A_RCNT  = 8'h3E;
    localparam logic [7:0] A_BC0   = 8'h40;
    localparam logic [7:0] A_PULSE = 8'h61;

    localparam int PB_HARD  = 0;
    localparam int PB_START = 1;
    localparam int PB_STOP  = 2;
    localparam int PB_SOFT  = 3;
    localparam int PB_TEST  = 5;

    localparam int CB_LEVEL  = 0;
    localparam int CB_CMD_EN = 11;

endpackage

// File: rtl/tcm_edge_sync.sv
module tcm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_out,
    output logic level_prev
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign level_out  = chain_q[STAGES-1];
    assign level_prev = chain_q[STAGES];
endmodule

// File: rtl/tcm_sat_counter.sv
module tcm_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (clr)                  count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end

    // R11: a full counter never wraps back
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && !clr) |=> count == MAXV);

    // R12 / R9: a clear request empties the counter
    a_r12_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/tcm_run_fsm.sv
module tcm_run_fsm
    import tcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hard_clr,
    input  logic start_req,
    input  logic stop_req,
    output logic running
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (hard_clr) begin
            state_d = RS_IDLE;
        end else begin
            unique case (state_q)
                RS_IDLE: if (start_req) state_d = RS_RUN;
                RS_RUN:  if (!start_req && stop_req) state_d = RS_HALT;
                RS_HALT: if (start_req) state_d = RS_RUN;
                default: state_d = RS_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            RS_RUN:  running = 1'b1;
            default: running = 1'b0;
        endcase
    end

    // R3: a start request wins over a stop request
    a_r3_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !hard_clr) |=> running);

    // R3: a lone stop request ends the run
    a_r3_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !start_req && !hard_clr && state_q == RS_RUN) |=> state_q == RS_HALT);

    // R12: hard reset returns to idle
    a_r12_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> state_q == RS_IDLE);
endmodule

// File: rtl/tcm_monitor.sv
module tcm_monitor
    import tcm_pkg::*;
#(
    parameter int           CMD_W       = 8,
    parameter int           NUM_CODES   = 16,
    parameter int           CNT_W       = 16,
    parameter int           SYNC_STAGES = 2,
    parameter logic [15:0]  VERSION     = 16'h7003,
    parameter logic [7:0]   CMD_START   = 8'h01,
    parameter logic [7:0]   CMD_STOP    = 8'h02
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [15:0]  bus_wdata,
    output logic [15:0]  bus_rdata,
    input  logic [CMD_W-1:0] tcmd,
    input  logic         tcmd_vld,
    input  logic         tclk_in,
    input  logic         rxclk_in,
    input  logic         bc0_in,
    input  logic         tlock_in,
    output logic         test_out_p,
    output logic         test_out_n
);
    localparam int LOSS_W = 3;

    logic [15:0]      ctrl_q;
    logic [CMD_W-1:0] last_q;
    logic             pulse_q;
    logic             pulse_wr, ctrl_wr;
    logic             hard_clr, soft_clr;
    logic             start_req, stop_req, running;
    logic             tclk_lvl, tclk_prv, rclk_lvl, rclk_prv, lock_lvl, lock_prv;
    logic [CNT_W-1:0] tclk_cnt, rclk_cnt, bc0_cnt;
    logic [CNT_W-1:0] hist_cnt [NUM_CODES];
    logic [LOSS_W-1:0] loss_cnt;

    assign pulse_wr = bus_wr && (bus_addr == A_PULSE);
    assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
    assign hard_clr = pulse_wr && bus_wdata[PB_HARD];
    assign soft_clr = pulse_wr && bus_wdata[PB_SOFT];

    assign start_req = (pulse_wr && bus_wdata[PB_START]) ||
                       (ctrl_q[CB_CMD_EN] && tcmd_vld && tcmd == CMD_W'(CMD_START));
    assign stop_req  = (pulse_wr && bus_wdata[PB_STOP]) ||
                       (ctrl_q[CB_CMD_EN] && tcmd_vld && tcmd == CMD_W'(CMD_STOP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            last_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_wr && bus_wdata[PB_TEST];
            if (hard_clr) begin
                ctrl_q <= '0;
                last_q <= '0;
            end else begin
                if (ctrl_wr)  ctrl_q <= bus_wdata;
                if (tcmd_vld) last_q <= tcmd;
            end
        end
    end

    tcm_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hard_clr  (hard_clr),
        .start_req (start_req),
        .stop_req  (stop_req),
        .running   (running)
    );

    tcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_tclk (
        .clk(clk), .rst_n(rst_n), .async_in(tclk_in),
        .level_out(tclk_lvl), .level_prev(tclk_prv));
    tcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_rclk (
        .clk(clk), .rst_n(rst_n), .async_in(rxclk_in),
        .level_out(rclk_lvl), .level_prev(rclk_prv));
    tcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
        .clk(clk), .rst_n(rst_n), .async_in(tlock_in),
        .level_out(lock_lvl), .level_prev(lock_prv));

    tcm_sat_counter #(.W(CNT_W)) u_tcnt (
        .clk(clk), .rst_n(rst_n), .clr(hard_clr || soft_clr),
        .inc(running && tclk_lvl && !tclk_prv), .count(tclk_cnt));
    tcm_sat_counter #(.W(CNT_W)) u_rcnt (
        .clk(clk), .rst_n(rst_n), .clr(hard_clr || soft_clr),
        .inc(running && rclk_lvl && !rclk_prv), .count(rclk_cnt));
    tcm_sat_counter #(.W(CNT_W)) u_bc0 (
        .clk(clk), .rst_n(rst_n), .clr(hard_clr),
        .inc(bc0_in), .count(bc0_cnt));
    tcm_sat_counter #(.W(LOSS_W)) u_loss (
        .clk(clk), .rst_n(rst_n), .clr(hard_clr),
        .inc(lock_prv && !lock_lvl), .count(loss_cnt));

    for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_hist
        tcm_sat_counter #(.W(CNT_W)) u_bin (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (hard_clr),
            .inc   (tcmd_vld && tcmd == CMD_W'(gi)),
            .count (hist_cnt[gi])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_ONES:  bus_rdata = 16'hFFFF;
            A_ZEROS: bus_rdata = 16'h0000;
            A_VER:   bus_rdata = VERSION;
            A_STAT:  bus_rdata = {5'b0, loss_cnt, 4'b0, lock_lvl, 1'b0, running, 1'b0};
            A_LAST:  bus_rdata = 16'(last_q);
            A_TCNT:  bus_rdata = 16'(tclk_cnt);
            A_RCNT:  bus_rdata = 16'(rclk_cnt);
            A_BC0:   bus_rdata = 16'(bc0_cnt);
            default: begin
                for (int i = 0; i < NUM_CODES; i++)
                    if (bus_addr == A_HIST + 8'(i)) bus_rdata = 16'(hist_cnt[i]);
            end
        endcase
    end

    assign test_out_p = ctrl_q[CB_LEVEL] | pulse_q;
    assign test_out_n = ~test_out_p;

    // R13: a test-pulse write shows on the output in the following cycle
    a_r13_pulse_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_wr && bus_wdata[PB_TEST]) |=> test_out_p);

    // R7: timing-clock counter frozen outside the run
    a_r7_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !hard_clr && !soft_clr) |=> $stable(tclk_cnt));

    // R8: receive-clock counter frozen outside the run
    a_r8_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !hard_clr && !soft_clr) |=> $stable(rclk_cnt));

    // R12: hard reset empties the control register
    a_r12_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> ctrl_q == '0 && !running);
endmodule

// File: tb/tb_tcm_monitor.sv
`timescale 1ns/1ps
module tb_tcm_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  tcmd = '0;
    logic        tcmd_vld = 1'b0;
    logic        tclk_in = 1'b0, rxclk_in = 1'b0, bc0_in = 1'b0, tlock_in = 1'b0;
    logic        test_out_p, test_out_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tcm_monitor dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tcmd(tcmd),
        .tcmd_vld(tcmd_vld), .tclk_in(tclk_in), .rxclk_in(rxclk_in),
        .bc0_in(bc0_in), .tlock_in(tlock_in),
        .test_out_p(test_out_p), .test_out_n(test_out_n));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        tcmd = c; tcmd_vld = 1'b1;
        @(negedge clk);
        tcmd_vld = 1'b0;
    endtask

    // which: 0 timing clock, 1 receive clock
    task automatic pulses(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (which == 0) tclk_in = 1'b1; else rxclk_in = 1'b1;
            repeat (3) @(negedge clk);
            if (which == 0) tclk_in = 1'b0; else rxclk_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic lock_fall();
        @(negedge clk); tlock_in = 1'b1;
        repeat (3) @(negedge clk); tlock_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state and fixed registers
        rd(8'h00, 16'h0000, "R2 ctrl reset");
        rd(8'h10, 16'h0000, "R3 status reset");
        rd(8'h01, 16'hFFFF, "R1 ones");
        rd(8'h02, 16'h0000, "R1 zeros");
        rd(8'h03, 16'h7003, "R1 version");
        rd(8'h61, 16'h0000, "R1 write-only reads zero");
        rd(8'h55, 16'h0000, "R1 unmapped");
        rd(8'h3D, 16'h0000, "R7 reset");

        // control level
        wr(8'h00, 16'hA5C1);
        rd(8'h00, 16'hA5C1, "R2 readback");
        check("R2 level p", 16'(test_out_p), 16'd1);
        check("R2 level n", 16'(test_out_n), 16'd0);
        wr(8'h00, 16'h0000);
        check("R2 level off", 16'(test_out_p), 16'd0);

        // one-cycle test pulse
        @(negedge clk);
        bus_addr = 8'h61; bus_wdata = 16'h0020; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        check("R13 pulse high", 16'(test_out_p), 16'd1);
        check("R13 pulse n", 16'(test_out_n), 16'd0);
        @(negedge clk);
        check("R13 pulse one cycle", 16'(test_out_p), 16'd0);

        // histogram sweep, command start/stop disabled
        for (int c = 0; c < 16; c++)
            for (int k = 0; k <= c; k++) send_cmd(8'(c));
        for (int c = 16; c < 21; c++) send_cmd(8'(c));
        send_cmd(8'hFF);
        for (int c = 0; c < 16; c++)
            rd(8'h20 + 8'(c), 16'(c + 1), $sformatf("R6 bin %0d", c));
        rd(8'h18, 16'h00FF, "R5 last command");
        rd(8'h10, 16'h0000, "R4 disabled commands ignored");

        // clock counters gated by run state
        pulses(0, 4);
        pulses(1, 2);
        rd(8'h3D, 16'h0000, "R7 idle no count");
        rd(8'h3E, 16'h0000, "R8 idle no count");
        wr(8'h61, 16'h0002);
        rd(8'h10, 16'h0002, "R3 start");
        pulses(0, 5);
        pulses(1, 7);
        rd(8'h3D, 16'd5, "R7 run count");
        rd(8'h3E, 16'd7, "R8 run count");
        wr(8'h61, 16'h0004);
        rd(8'h10, 16'h0000, "R3 stop");
        pulses(0, 3);
        pulses(1, 3);
        rd(8'h3D, 16'd5, "R7 halt frozen");
        rd(8'h3E, 16'd7, "R8 halt frozen");
        wr(8'h61, 16'h0006);
        rd(8'h10, 16'h0002, "R3 start wins over stop");
        wr(8'h61, 16'h0008);
        rd(8'h3D, 16'd0, "R9 soft clears tclk");
        rd(8'h3E, 16'd0, "R9 soft clears rxclk");
        rd(8'h10, 16'h0002, "R9 run kept");
        rd(8'h23, 16'd4, "R9 histogram kept");
        rd(8'h18, 16'h00FF, "R9 last command kept");

        // command-driven run control
        wr(8'h61, 16'h0004);
        send_cmd(8'h01);
        rd(8'h10, 16'h0000, "R4 start ignored when disabled");
        wr(8'h00, 16'h0800);
        send_cmd(8'h01);
        rd(8'h10, 16'h0002, "R4 command start");
        send_cmd(8'h02);
        rd(8'h10, 16'h0000, "R4 command stop");
        send_cmd(8'h01);
        rd(8'h10, 16'h0002, "R4 command resume");

        // lock status and loss counter
        @(negedge clk); tlock_in = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h10, 16'h000A, "R14 lock visible");
        @(negedge clk); tlock_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h10, 16'h0102, "R14 one loss");
        for (int k = 0; k < 8; k++) lock_fall();
        rd(8'h10, 16'h0702, "R14 loss saturates at 7");

        // bunch-zero counter
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); bc0_in = 1'b1;
            @(negedge clk); bc0_in = 1'b0;
        end
        rd(8'h40, 16'd10, "R10 bc0 count");
        @(negedge clk); bc0_in = 1'b1;
        repeat (65530) @(negedge clk);
        bc0_in = 1'b0;
        rd(8'h40, 16'hFFFF, "R11 saturate");
        rd(8'h3D, 16'd0, "R10 bc0 leaves clocks");

        // hard reset
        wr(8'h00, 16'h0801);
        wr(8'h61, 16'h0001);
        rd(8'h00, 16'h0000, "R12 ctrl cleared");
        rd(8'h10, 16'h0000, "R12 idle and loss cleared");
        rd(8'h40, 16'h0000, "R12 bc0 cleared");
        rd(8'h2F, 16'h0000, "R12 histogram cleared");
        rd(8'h18, 16'h0000, "R12 last cleared");
        check("R12 level cleared", 16'(test_out_p), 16'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule